// File: doc/BRIEF.md
# Serial Synthesizer Channel Programmer

This block turns a channel number into the two setup words that an external integer-N frequency synthesizer expects. It sends them over a three-wire serial link made of a serial clock, a data line and a load strobe. The total division is a fixed base value plus the channel number, so each channel step adds one to it. The division is split into a programmable count and a swallow count that suit a dual-modulus prescaler. A reference word carrying the reference divider and the fixed mode bits is sent first. A divider word follows.

A host places a channel number and the prescaler-select bit on the inputs and pulses `start`. The block shifts each 19-bit word out MSB first and strobes the load line after each word. It raises `done` for one cycle once the second word has been latched. Every minimum timing gap on the link is a parameter counted in system clock cycles. A channel whose counts cannot be represented is refused: `err` goes high and the link stays quiet.

Top module: `pll_prog_ctrl`

## Requirements
- R1: After reset, `ser_clk`, `ser_data`, `ser_le`, `busy`, `done` and `err` are all 0.
- R2: With n = BASE_DIV + chan_idx and M = MODULUS (64), the divider word is {N[10:0], A[6:0], 0}. Here N = floor(n/M) and A = n mod M, and the trailing 0 is the latch-select bit.
- R3: The reference word is {0, 0, 1, sw_sel, R[13:0], 1}, with R = REF_DIV (1700 by default). It is always sent before the divider word.
- R4: Bits leave MSB first and are taken on each rising `ser_clk`. Data is steady for at least T_SETUP cycles before the rise and for the whole high phase. `ser_clk` stays high for exactly T_CLK_HI cycles.
- R5: `ser_le` is low while bits shift and never high together with `ser_clk`. Each word has exactly 19 rising clocks. `ser_le` rises exactly T_LE_GAP cycles after the last clock fall and stays high exactly T_LE_HIGH cycles.
- R6: Between the two words, `ser_le` stays low at least T_WORD_GAP cycles before the next clock rise.
- R7: `busy` is 1 in the cycle after an accepted `start`. `done` is a single-cycle pulse with `busy` low. It arrives after T_WORD_GAP+1 low cycles of `ser_le` following the second strobe.
- R8: If N > 2047, N < 3 or A ≥ N, `err` is set, `busy` stays low and no clock or strobe edge appears. A later valid `start` clears `err`.
- R9: A `start` pulse while `busy` is high is ignored, and the words of the running transfer are unchanged.
- R10: One channel step at the swallow boundary carries into N: n = 34944 gives N = 546 and A = 0, while n = 34943 gives N = 545 and A = 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin programming the given channel |
| chan_idx | input | CH_W | Channel number added to the base division |
| sw_sel | input | 1 | Prescaler-select bit placed in the reference word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the second word is latched |
| err | output | 1 | Last request had unrepresentable counts |
| ser_clk | output | 1 | Serial shift clock |
| ser_data | output | 1 | Serial data, MSB first |
| ser_le | output | 1 | Load strobe that latches the shifted word |

## Verification
Each result has a known cycle offset. `busy` and `err` follow `start` by one cycle. A clock rise comes T_SETUP cycles after its data changes, and the high phase lasts T_CLK_HI cycles. The strobe rises T_LE_GAP cycles after the last fall and lasts T_LE_HIGH cycles. `done` follows T_WORD_GAP+1 cycles after the final strobe falls. The bench samples every output on the falling system edge and counts those samples from the preceding event. It compares each count for exact equality, or for a lower bound where only a minimum is specified. Stimulus is applied on the same falling edge. Captured words are compared only after `done`.

// File: rtl/pllp_pkg.sv
// Shared types for the synthesizer programmer.
// Assumes the synthesizer register is 19 bits wide with the select bit last.
package pllp_pkg;
    localparam int WORD_W = 19;
    typedef logic [WORD_W-1:0] pll_word_t;
    typedef enum logic [1:0] {TOP_IDLE, TOP_REF, TOP_DIV} top_state_t;
    typedef enum logic [2:0] {SH_IDLE, SH_LOW, SH_HIGH, SH_PRE, SH_STRB, SH_POST} sh_state_t;
endpackage

// File: rtl/pllp_divcalc.sv
// Computes the swallow and programmable counts from a channel number and
// packs both serial words. Assumes MODULUS is a power of two up to 128.
module pllp_divcalc
    import pllp_pkg::*;
#(
    parameter int BASE_DIV = 34904,
    parameter int MODULUS  = 64,
    parameter int REF_DIV  = 1700,
    parameter int CH_W     = 17
) (
    input  logic [CH_W-1:0] chan_idx,
    input  logic            sw_sel,
    output pll_word_t       ref_word,
    output pll_word_t       div_word,
    output logic            valid
);
    localparam int SH = $clog2(MODULUS);
    localparam int NW = $clog2(BASE_DIV + (1 << CH_W)) + 1;

    logic [NW-1:0] n_tot, n_cnt, a_cnt;
    logic [6:0]    a_fld;
    logic [13:0]   r_fld;

    // Total division, split into programmable and swallow counts.
    always_comb begin
        n_tot = NW'(BASE_DIV) + NW'(chan_idx);
        n_cnt = n_tot >> SH;
        a_cnt = NW'(n_tot[SH-1:0]);
        a_fld = 7'(n_tot[SH-1:0]);
        r_fld = 14'(REF_DIV);
        valid = (n_cnt <= NW'(2047)) && (n_cnt >= NW'(3)) && (a_cnt < n_cnt);
    end

    // Word packing: mode bits, reference count and select bit 1; counts and select bit 0.
    always_comb begin
        ref_word = {1'b0, 1'b0, 1'b1, sw_sel, r_fld, 1'b1};
        div_word = {n_cnt[10:0], a_fld, 1'b0};
    end
endmodule

// File: rtl/pllp_shifter.sv
// Shifts one 19-bit word MSB first on a three-wire link, then strobes
// the load line. All gaps are counted in system cycles; each must be >= 1.
module pllp_shifter
    import pllp_pkg::*;
#(
    parameter int T_SETUP   = 3,
    parameter int T_CLK_HI  = 3,
    parameter int T_LE_GAP  = 4,
    parameter int T_LE_HIGH = 13,
    parameter int T_WORD_GAP = 13
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  pll_word_t word,
    output logic      ser_clk,
    output logic      ser_data,
    output logic      ser_le,
    output logic      word_done
);
    localparam int CW = $clog2(T_SETUP + T_CLK_HI + T_LE_GAP + T_LE_HIGH + T_WORD_GAP + 1);
    localparam int BW = $clog2(WORD_W);

    sh_state_t     st;
    pll_word_t     sreg;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bit_i;

    // Bit and gap sequencer driving the three link wires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= SH_IDLE; sreg <= '0; cnt <= '0; bit_i <= '0;
            ser_clk <= 1'b0; ser_data <= 1'b0; ser_le <= 1'b0; word_done <= 1'b0;
        end else begin
            word_done <= 1'b0;
            case (st)
                SH_IDLE: if (load) begin
                    sreg <= word; ser_data <= word[WORD_W-1];
                    bit_i <= '0; cnt <= '0; st <= SH_LOW;
                end
                SH_LOW: if (cnt == CW'(T_SETUP - 1)) begin
                    ser_clk <= 1'b1; cnt <= '0; st <= SH_HIGH;
                end else cnt <= cnt + 1'b1;
                SH_HIGH: if (cnt == CW'(T_CLK_HI - 1)) begin
                    ser_clk <= 1'b0; cnt <= '0;
                    if (bit_i == BW'(WORD_W - 1)) st <= SH_PRE;
                    else begin
                        sreg <= {sreg[WORD_W-2:0], 1'b0};
                        ser_data <= sreg[WORD_W-2];
                        bit_i <= bit_i + 1'b1;
                        st <= SH_LOW;
                    end
                end else cnt <= cnt + 1'b1;
                SH_PRE: if (cnt == CW'(T_LE_GAP - 1)) begin
                    ser_le <= 1'b1; cnt <= '0; st <= SH_STRB;
                end else cnt <= cnt + 1'b1;
                SH_STRB: if (cnt == CW'(T_LE_HIGH - 1)) begin
                    ser_le <= 1'b0; cnt <= '0; st <= SH_POST;
                end else cnt <= cnt + 1'b1;
                SH_POST: if (cnt == CW'(T_WORD_GAP - 1)) begin
                    word_done <= 1'b1; cnt <= '0; st <= SH_IDLE;
                end else cnt <= cnt + 1'b1;
                default: st <= SH_IDLE;
            endcase
        end
    end

    // R5
    le_clk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ser_le && ser_clk));
    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));
    // R5
    le_after_last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_le) |-> (bit_i == BW'(WORD_W - 1)));
endmodule

// File: rtl/pll_prog_ctrl.sv
// Top level: validates the channel, then sends the reference word and
// the divider word in that order and pulses done. Start is ignored while busy.
module pll_prog_ctrl
    import pllp_pkg::*;
#(
    parameter int BASE_DIV   = 34904,
    parameter int MODULUS    = 64,
    parameter int REF_DIV    = 1700,
    parameter int CH_W       = 17,
    parameter int T_SETUP    = 3,
    parameter int T_CLK_HI   = 3,
    parameter int T_LE_GAP   = 4,
    parameter int T_LE_HIGH  = 13,
    parameter int T_WORD_GAP = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [CH_W-1:0] chan_idx,
    input  logic            sw_sel,
    output logic            busy,
    output logic            done,
    output logic            err,
    output logic            ser_clk,
    output logic            ser_data,
    output logic            ser_le
);
    top_state_t st;
    pll_word_t  ref_w, div_w, div_q, load_w;
    logic       ok, load_q, word_done;

    pllp_divcalc #(.BASE_DIV(BASE_DIV), .MODULUS(MODULUS), .REF_DIV(REF_DIV), .CH_W(CH_W))
        calc_i (.chan_idx(chan_idx), .sw_sel(sw_sel), .ref_word(ref_w), .div_word(div_w), .valid(ok));

    pllp_shifter #(.T_SETUP(T_SETUP), .T_CLK_HI(T_CLK_HI), .T_LE_GAP(T_LE_GAP),
                   .T_LE_HIGH(T_LE_HIGH), .T_WORD_GAP(T_WORD_GAP))
        shf_i (.clk(clk), .rst_n(rst_n), .load(load_q), .word(load_w),
               .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le), .word_done(word_done));

    // Transfer sequencing: accept request, issue reference then divider word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= TOP_IDLE; load_q <= 1'b0; load_w <= '0; div_q <= '0;
            done <= 1'b0; err <= 1'b0;
        end else begin
            load_q <= 1'b0;
            done   <= 1'b0;
            case (st)
                TOP_IDLE: if (start) begin
                    err <= !ok;
                    if (ok) begin
                        load_w <= ref_w; div_q <= div_w; load_q <= 1'b1; st <= TOP_REF;
                    end
                end
                TOP_REF: if (word_done) begin
                    load_w <= div_q; load_q <= 1'b1; st <= TOP_DIV;
                end
                TOP_DIV: if (word_done) begin
                    done <= 1'b1; st <= TOP_IDLE;
                end
                default: st <= TOP_IDLE;
            endcase
        end
    end

    assign busy = (st != TOP_IDLE);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !ser_clk && !ser_le));
endmodule

// File: tb/pll_prog_ctrl_tb_top.sv
// Directed bench: one task per scenario; a negedge monitor captures words
// and measures link timing in system cycles.
module pll_prog_ctrl_tb_top;
    localparam int TS = 3, TH = 3, TG = 4, TL = 13, TW = 13, CHW = 17;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sw_sel = 1'b0;
    logic [CHW-1:0] chan_idx = '0;
    logic busy, done, err, ser_clk, ser_data, ser_le;

    int errors = 0, checks = 0;

    always #4 clk = ~clk;

    pll_prog_ctrl #(.CH_W(CHW), .T_SETUP(TS), .T_CLK_HI(TH), .T_LE_GAP(TG),
                    .T_LE_HIGH(TL), .T_WORD_GAP(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .chan_idx(chan_idx), .sw_sel(sw_sel),
        .busy(busy), .done(done), .err(err),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor state
    logic [18:0] sh_in = '0;
    logic [18:0] cap [0:1];
    int words = 0, bits = 0, edges = 0, strobes = 0, dones = 0;
    int hi_cnt = 0, stab_cnt = 0, low_cnt = 0, lelo_cnt = 0, lehi_cnt = 0;
    logic p_clk = 0, p_le = 0, p_data = 0, after_strobe = 0;

    // Link monitor sampled on the falling system edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ser_data != p_data) stab_cnt = 1;
            else if (!ser_clk) stab_cnt++;
            if (ser_clk && !p_clk) begin
                edges++;
                chk(stab_cnt >= TS, "R4 setup cycles", stab_cnt, TS);
                chk(!ser_le, "R5 strobe low while shifting", ser_le, 0);
                if (bits == 0 && after_strobe)
                    chk(lelo_cnt >= TW, "R6 word gap", lelo_cnt, TW);
                sh_in = {sh_in[17:0], ser_data};
                bits++;
                hi_cnt = 1;
            end else if (ser_clk) begin
                hi_cnt++;
                if (ser_data != p_data) chk(0, "R4 data held while high", ser_data, p_data);
            end
            if (!ser_clk && p_clk) begin
                chk(hi_cnt == TH, "R4 clock high width", hi_cnt, TH);
                low_cnt = 1;
            end else if (ser_le && !p_le) begin
                strobes++;
                chk(low_cnt == TG, "R5 last fall to strobe", low_cnt, TG);
                chk(bits == 19, "R5 clocks per word", bits, 19);
                if (words < 2) cap[words] = sh_in;
                words++;
                bits = 0;
                lehi_cnt = 1;
            end else if (ser_le) lehi_cnt++;
            else if (!ser_clk) low_cnt++;
            if (!ser_le && p_le) begin
                chk(lehi_cnt == TL, "R5 strobe width", lehi_cnt, TL);
                lelo_cnt = 1;
                after_strobe = 1;
            end else if (done) begin
                dones++;
                chk(lelo_cnt == TW + 1, "R7 done delay", lelo_cnt, TW + 1);
                chk(!busy, "R7 done with busy low", busy, 0);
                after_strobe = 0;
            end else if (!ser_le) lelo_cnt++;
            p_clk = ser_clk; p_le = ser_le; p_data = ser_data;
        end
    end

    function automatic logic [18:0] exp_ref(input logic s);
        return {3'b001, s, 14'd1700, 1'b1};
    endfunction

    function automatic logic [18:0] exp_div(input int ch);
        int n = 34904 + ch;
        int nn = n / 64;
        int aa = n % 64;
        return {nn[10:0], aa[6:0], 1'b0};
    endfunction

    task automatic wait_done(output bit got);
        got = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (done) begin got = 1; break; end
        end
    endtask

    // Run one valid transfer and check both captured words.
    task automatic xfer(input int ch, input logic s, input string req);
        bit got;
        words = 0;
        @(negedge clk);
        chan_idx = CHW'(ch); sw_sel = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R7 busy after start", busy, 1);
        chk(!err, "R8 err clear on valid start", err, 0);
        wait_done(got);
        chk(got, "R7 done seen", got, 1);
        @(posedge clk);
        chk(words == 2, "R5 two strobes", words, 2);
        chk(cap[0] == exp_ref(s), {req, " R3 reference word"}, cap[0], exp_ref(s));
        chk(cap[1] == exp_div(ch), {req, " R2 divider word"}, cap[1], exp_div(ch));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(!ser_clk && !ser_data && !ser_le, "R1 link idle", {ser_clk, ser_data, ser_le}, 0);
        chk(!busy && !done && !err, "R1 status idle", {busy, done, err}, 0);
    endtask

    task automatic t_invalid(input int ch);
        int e0 = edges, s0 = strobes;
        @(negedge clk);
        chan_idx = CHW'(ch); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(err, "R8 err set", err, 1);
        chk(!busy, "R8 busy stays low", busy, 0);
        repeat (200) @(negedge clk);
        @(posedge clk);
        chk(edges == e0 && strobes == s0, "R8 nothing sent", edges - e0 + strobes - s0, 0);
    endtask

    task automatic t_start_while_busy;
        bit got;
        int d0;
        words = 0;
        @(negedge clk);
        chan_idx = CHW'(7); sw_sel = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (60) @(negedge clk);
        chan_idx = CHW'(300); sw_sel = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R9 still busy", busy, 1);
        d0 = dones;
        wait_done(got);
        repeat (400) @(negedge clk);
        @(posedge clk);
        chk(dones == d0 + 1, "R9 single done", dones - d0, 1);
        chk(cap[0] == exp_ref(1'b0), "R9 reference word unchanged", cap[0], exp_ref(1'b0));
        chk(cap[1] == exp_div(7), "R9 divider word unchanged", cap[1], exp_div(7));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        xfer(0, 1'b0, "base");              // R2: N=545 A=24
        xfer(39, 1'b0, "R10 A=63");         // n=34943
        xfer(40, 1'b0, "R10 carry");        // n=34944: N=546 A=0
        xfer(1234, 1'b1, "R3 sw set");
        xfer(96167, 1'b0, "R8 N=2047 edge"); // n=131071
        t_invalid(96168);                   // R8: N=2048
        xfer(5, 1'b0, "R8 recovery");
        t_start_while_busy();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule